// File: doc/BRIEF.md
# Selectable Dual-Ratio Clock Divider

This block derives two slower clocks from one input clock. Output A runs at one half or one quarter of the input rate. Output B runs at one quarter, one fifth or one sixth of it. Both dividers advance on the same rising edges of the input clock, so wherever their rising edges coincide they fall on the same input cycle. The odd ratio is included in that guarantee.

A freeze input is captured on the falling edge of the input clock. Both dividers therefore stop and restart only between a falling edge and the next rising edge. This means a frozen or resumed output never gets a shortened high or low phase. An asynchronous, active-high master reset clears every counter and drives both outputs low. When several copies share the same reset release, they start in lock-step.

Select changes are held back until the divider concerned finishes its current period. The outputs are registered on the rising input edge and are glitch-free.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: While `mr` is high, `q_a` and `q_b` are low and all divider state is cleared, whatever `en` and the selects do.
- R2: After `mr` falls, the first rising clock edge at which the dividers advance drives both `q_a` and `q_b` high on that same edge.
- R3: With `sel_a` = 0, `q_a` has a period of 2 advancing edges (1 high, 1 low). With `sel_a` = 1, the period is 4 (2 high, 2 low).
- R4: Output B ratio is selected by {`sel_b0`,`sel_b1`}: 00 gives a period of 4 (2 high, 2 low), 01 gives 6 (3 high, 3 low), and 10 or 11 give 5 (2 high, 3 low).
- R5: `en` is active-high freeze and is sampled on the falling clock edge. If `en` is high at a falling edge, the following rising edge leaves both outputs and both counters unchanged.
- R6: After a freeze ends, both dividers resume from the phase where they stopped, with no skipped or repeated edge.
- R7: A select change made during a period does not affect that period. The new ratio applies from the rising edge that starts the next period of that divider.
- R8: Each output is high on the rising edge that begins a period and low on the rising edge that ends it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| mr | input | 1 | Asynchronous master reset, active high |
| en | input | 1 | Freeze request, active high, sampled on falling clk edge |
| sel_a | input | 1 | Output A ratio select (0: /2, 1: /4) |
| sel_b0 | input | 1 | Output B ratio select, upper bit |
| sel_b1 | input | 1 | Output B ratio select, lower bit |
| q_a | output | 1 | Divided clock A |
| q_b | output | 1 | Divided clock B |

## Verification
Three functions can land on the same rising edge: a freeze, a divider wrap with a select change pending, and a reset. The bench provokes the first two together by asserting the freeze at a wrap point while new selects are already applied. It provokes the last by raising reset while a freeze is in effect. A bench-side reference model of two phase counters runs alongside the design. It advances only on edges that follow a low freeze sample and latches each ratio only at a period start. Every rising edge is compared against this model, so a freeze that leaks, a ratio adopted too early or a reset that yields to the freeze each shows up as a wrong output level.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  // Counter and ratio width; ratios up to 7 fit.
  localparam int unsigned CW = 3;

  typedef logic [CW-1:0] ratio_t;

  // Output A: half or quarter rate.
  function automatic ratio_t ratio_for_a(input logic sel);
    return sel ? ratio_t'(4) : ratio_t'(2);
  endfunction

  // Output B: {upper,lower} 00 -> 4, 01 -> 6, 1x -> 5.
  function automatic ratio_t ratio_for_b(input logic upper, input logic lower);
    if (upper)      return ratio_t'(5);
    else if (lower) return ratio_t'(6);
    else            return ratio_t'(4);
  endfunction

  // High phase length: floor(ratio/2), so odd ratios are high the shorter part.
  function automatic ratio_t high_len(input ratio_t r);
    return r >> 1;
  endfunction

endpackage

// File: rtl/dcd_freeze_sync.sv
module dcd_freeze_sync (
  input  logic clk,
  input  logic mr,
  input  logic en,
  output logic frozen
);

  // Captured on the falling edge so gating changes only while clk is low.
  always_ff @(negedge clk or posedge mr) begin
    if (mr) frozen <= 1'b0;
    else    frozen <= en;
  end

endmodule

// File: rtl/dcd_divider.sv
module dcd_divider
  import dcd_pkg::*;
(
  input  logic   clk,
  input  logic   mr,
  input  logic   adv,
  input  ratio_t req_ratio,
  output logic   q,
  output logic   at_start,
  output logic   at_wrap,
  output ratio_t ratio_act
);

  ratio_t cnt;
  ratio_t ratio_q;

  // A new ratio is taken only when a period begins.
  assign at_start  = (cnt == '0);
  assign ratio_act = at_start ? req_ratio : ratio_q;
  assign at_wrap   = (cnt == ratio_act - ratio_t'(1));

  always_ff @(posedge clk or posedge mr) begin
    if (mr) begin
      cnt     <= '0;
      ratio_q <= '0;
      q       <= 1'b0;
    end else if (adv) begin
      ratio_q <= ratio_act;
      q       <= (cnt < high_len(ratio_act));
      cnt     <= at_wrap ? '0 : cnt + ratio_t'(1);
    end
  end

endmodule

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv
  import dcd_pkg::*;
(
  input  logic clk,
  input  logic mr,
  input  logic en,
  input  logic sel_a,
  input  logic sel_b0,
  input  logic sel_b1,
  output logic q_a,
  output logic q_b
);

  logic   frozen;
  logic   adv;
  logic   a_start, a_wrap, b_start, b_wrap;
  ratio_t a_ratio, b_ratio;

  dcd_freeze_sync i_freeze (
    .clk    (clk),
    .mr     (mr),
    .en     (en),
    .frozen (frozen)
  );

  // Shared timebase strobe for both dividers.
  assign adv = !frozen;

  dcd_divider i_div_a (
    .clk       (clk),
    .mr        (mr),
    .adv       (adv),
    .req_ratio (ratio_for_a(sel_a)),
    .q         (q_a),
    .at_start  (a_start),
    .at_wrap   (a_wrap),
    .ratio_act (a_ratio)
  );

  dcd_divider i_div_b (
    .clk       (clk),
    .mr        (mr),
    .adv       (adv),
    .req_ratio (ratio_for_b(sel_b0, sel_b1)),
    .q         (q_b),
    .at_start  (b_start),
    .at_wrap   (b_wrap),
    .ratio_act (b_ratio)
  );

endmodule

// File: rtl/dcd_checker.sv
module dcd_checker
  import dcd_pkg::*;
(
  input logic   clk,
  input logic   mr,
  input logic   q_a,
  input logic   q_b,
  input logic   adv,
  input logic   frozen,
  input logic   a_start,
  input logic   a_wrap,
  input logic   b_start,
  input logic   b_wrap,
  input ratio_t b_ratio
);

  p_reset_low_r1: assert property (@(posedge clk) mr |-> (!q_a && !q_b));

  p_common_rise_r2: assert property (@(posedge clk) disable iff (mr)
    (adv && a_start && b_start) |=> (q_a && q_b));

  p_hold_r5: assert property (@(posedge clk) disable iff (mr)
    frozen |=> ($stable(q_a) && $stable(q_b)));

  p_ratio_kept_r7: assert property (@(posedge clk) disable iff (mr)
    (adv && !b_wrap) |=> (b_ratio == $past(b_ratio)));

  p_a_start_high_r8: assert property (@(posedge clk) disable iff (mr)
    (adv && a_start) |=> q_a);

  p_b_wrap_low_r8: assert property (@(posedge clk) disable iff (mr)
    (adv && b_wrap) |=> !q_b);

  p_a_wrap_low_r8: assert property (@(posedge clk) disable iff (mr)
    (adv && a_wrap) |=> !q_a);

endmodule

bind dual_ratio_clkdiv dcd_checker i_dcd_checker (
  .clk     (clk),
  .mr      (mr),
  .q_a     (q_a),
  .q_b     (q_b),
  .adv     (adv),
  .frozen  (frozen),
  .a_start (a_start),
  .a_wrap  (a_wrap),
  .b_start (b_start),
  .b_wrap  (b_wrap),
  .b_ratio (b_ratio)
);

// File: tb/test_dual_ratio_clkdiv.sv
module test_dual_ratio_clkdiv;

  logic clk = 1'b0;
  logic mr = 1'b1;
  logic en = 1'b0;
  logic sel_a = 1'b0;
  logic sel_b0 = 1'b0;
  logic sel_b1 = 1'b0;
  logic q_a, q_b;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model: phase and latched period per output.
  int pa = 0, pera = 2, pb = 0, perb = 4;
  logic ea = 1'b0, eb = 1'b0;

  always #5 clk = ~clk;

  dual_ratio_clkdiv i_dual_ratio_clkdiv (
    .clk(clk), .mr(mr), .en(en), .sel_a(sel_a),
    .sel_b0(sel_b0), .sel_b1(sel_b1), .q_a(q_a), .q_b(q_b)
  );

  function automatic int period_a(input logic s);
    return s ? 4 : 2;
  endfunction

  function automatic int period_b(input logic u, input logic l);
    case ({u, l})
      2'b00:   return 4;
      2'b01:   return 6;
      default: return 5;
    endcase
  endfunction

  // High phase lengths stated directly from R3/R4.
  function automatic int high_of(input int p);
    case (p)
      2: return 1;
      4: return 2;
      5: return 2;
      6: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input string sig, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, sig, act, exp, $time);
    end
  endtask

  // Entered and left at posedge+2.
  task automatic step(input logic e, input string ra, input string rb);
    en = e;
    @(posedge clk);
    if (!e) begin
      if (pa == 0) pera = period_a(sel_a);
      ea = (pa < high_of(pera));
      pa = (pa + 1) % pera;
      if (pb == 0) perb = period_b(sel_b0, sel_b1);
      eb = (pb < high_of(perb));
      pb = (pb + 1) % perb;
    end
    #1;
    check(ra, "q_a", q_a, ea);
    check(rb, "q_b", q_b, eb);
    #1;
  endtask

  // R1: reset forces both outputs low, even with a freeze pending.
  task automatic do_reset();
    mr = 1'b1;
    #1;
    check("R1", "q_a", q_a, 1'b0);
    check("R1", "q_b", q_b, 1'b0);
    @(posedge clk);
    #1;
    check("R1", "q_a", q_a, 1'b0);
    check("R1", "q_b", q_b, 1'b0);
    #1;
    mr = 1'b0;
    pa = 0; pb = 0; ea = 1'b0; eb = 1'b0;
  endtask

  // R2, R3, R4, R8: every select combination from reset.
  task automatic t_ratios();
    for (int s = 0; s < 8; s++) begin
      sel_a = s[2]; sel_b0 = s[1]; sel_b1 = s[0];
      en = 1'b0;
      do_reset();
      step(1'b0, "R2", "R2");
      check("R2", "q_a", q_a, 1'b1);
      check("R2", "q_b", q_b, 1'b1);
      for (int i = 0; i < 30; i++) step(1'b0, "R3", "R4");
    end
  endtask

  // R5, R6: freeze mid-period, on a wrap with a pending select change.
  task automatic t_freeze();
    sel_a = 1'b1; sel_b0 = 1'b1; sel_b1 = 1'b0;
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b0, "R8", "R8");
    for (int i = 0; i < 5; i++) step(1'b1, "R5", "R5");
    for (int i = 0; i < 12; i++) step(1'b0, "R6", "R6");
    // Reach a B wrap point (pb == 4), change selects, then freeze there.
    while (pb != 4) step(1'b0, "R6", "R6");
    sel_b0 = 1'b0; sel_b1 = 1'b1; sel_a = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, "R5", "R5");
    for (int i = 0; i < 20; i++) step(1'b0, "R7", "R7");
  endtask

  // R7: select change in the middle of a period.
  task automatic t_sel_change();
    sel_a = 1'b0; sel_b0 = 1'b0; sel_b1 = 1'b0;
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b0, "R3", "R4");
    sel_a = 1'b1; sel_b1 = 1'b1;
    for (int i = 0; i < 20; i++) step(1'b0, "R7", "R7");
    sel_b0 = 1'b1;
    for (int i = 0; i < 15; i++) step(1'b0, "R7", "R7");
  endtask

  // R1, R2: reset mid-count while frozen.
  task automatic t_reset_mid();
    sel_a = 1'b1; sel_b0 = 1'b1; sel_b1 = 1'b1;
    do_reset();
    for (int i = 0; i < 7; i++) step(1'b0, "R4", "R4");
    step(1'b1, "R5", "R5");
    en = 1'b1;
    do_reset();
    step(1'b0, "R2", "R2");
    check("R2", "q_a", q_a, 1'b1);
    check("R2", "q_b", q_b, 1'b1);
    for (int i = 0; i < 15; i++) step(1'b0, "R8", "R8");
  endtask

  initial begin
    @(posedge clk);
    #1;
    check("R1", "q_a", q_a, 1'b0);
    check("R1", "q_b", q_b, 1'b0);
    #1;
    t_ratios();
    t_freeze();
    t_sel_change();
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule